// File: doc/BRIEF.md
# Pipeline Bypass and Hazard Controller

This controller decides, for a five-stage integer pipeline (fetch, decode, execute, memory, writeback), where each execute-stage operand comes from and when the front of the pipe must pause or discard work. For each execute-stage source register it compares the destination of the instruction now in the memory stage and the one now in writeback. It then steers the operand multiplexer to the newest matching result, or to the register file when neither matches. No stall is needed for ordinary arithmetic dependencies.

Two events make the pipe give up cycles. A load in execute whose destination is read by the instruction in decode cannot be bypassed in time. The controller then holds the program counter and the fetch/decode register for one cycle and injects an empty slot into the decode/execute register. A mispredicted branch sends fetch to the correct target and squashes the younger wrong-path work. One instruction is squashed when branches resolve in decode, two when they resolve in execute; a build-time parameter picks which. A squash always takes precedence over a stall raised in the same cycle.

All decisions are combinational functions of the current stage contents, so each result applies in the same cycle that its inputs are presented. Register zero reads as constant zero and is excluded from every comparison.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: When the memory-stage instruction writes (mem_we=1) a nonzero register equal to an execute source and writeback does not also match, that operand's select is 2'b10 (memory-stage result).
- R2: When only the writeback instruction writes (wb_we=1) a nonzero register equal to an execute source, that operand's select is 2'b01 (writeback result).
- R3: When both the memory-stage and the writeback instruction match the same execute source, the select is 2'b10: the younger result wins.
- R4: With no enabled match, the select is 2'b00 (register file). Select value 2'b11 never appears.
- R5: A source or destination of register 0 never produces a nonzero select and never causes a stall.
- R6: When ex_is_load=1, ex_we=1 and ex_rd is nonzero and equals id_rs1 or id_rs2, front_hold and idex_bubble are both 1 in that cycle. A non-load producer in execute causes neither.
- R7: A writeback destination that equals a decode source causes no stall, because the register file writes before it reads within a cycle.
- R8: With RESOLVE_IN_EX=0, a resolved mispredict raises fetch_redirect and ifid_flush, with idex_flush low (one squashed instruction).
- R9: With RESOLVE_IN_EX=1, a resolved mispredict raises fetch_redirect, ifid_flush and idex_flush (two squashed instructions).
- R10: A branch that resolves as correctly predicted, or a mispredict flag without br_resolve, raises no flush and no redirect.
- R11: When a squash and a load-use stall occur in the same cycle, the flushes are raised and front_hold and idex_bubble stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used by the embedded checks |
| rst_n | input | 1 | Active-low reset; disables the embedded checks |
| id_rs1 | input | REG_AW | First source register of the decode-stage instruction |
| id_rs2 | input | REG_AW | Second source register of the decode-stage instruction |
| ex_rs1 | input | REG_AW | First source register of the execute-stage instruction |
| ex_rs2 | input | REG_AW | Second source register of the execute-stage instruction |
| ex_rd | input | REG_AW | Destination register of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a memory load |
| mem_rd | input | REG_AW | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | REG_AW | Destination register of the writeback-stage instruction |
| wb_we | input | 1 | Writeback-stage instruction writes a register |
| br_resolve | input | 1 | A branch is resolved this cycle in the configured stage |
| br_mispredict | input | 1 | The resolving branch was mispredicted |
| fwd_sel_a | output | 2 | First operand select: 00 register file, 01 writeback, 10 memory stage |
| fwd_sel_b | output | 2 | Second operand select, same encoding |
| front_hold | output | 1 | Hold program counter and fetch/decode register |
| idex_bubble | output | 1 | Load an empty slot into decode/execute register |
| ifid_flush | output | 1 | Squash the instruction entering decode |
| idex_flush | output | 1 | Squash the instruction entering execute |
| fetch_redirect | output | 1 | Restart fetch at the corrected branch target |

## Verification
Every result of this controller is due in the same cycle as the stage contents that cause it, with no register on the path. The bench therefore changes inputs just after a rising edge and compares all outputs at the following falling edge, before the next change. A behavioural model computes the expected selects, stall and squash from the current inputs alone. Two instances, one per branch-resolution setting, receive identical stimulus so that the one- and two-instruction squash cases are checked side by side.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } opnd_src_e;

    typedef struct packed {
        logic hold;
        logic bubble;
        logic flush_f;
        logic flush_d;
        logic redirect;
    } pipe_ctl_t;

endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_we,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    output logic [1:0]        sel
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic      hit_mem_d;
    logic      hit_wb_d;
    opnd_src_e sel_d;

    always_comb begin
        hit_mem_d = mem_we && (mem_rd != ZERO_REG) && (mem_rd == src);
        hit_wb_d  = wb_we  && (wb_rd  != ZERO_REG) && (wb_rd  == src);
        if (hit_mem_d)
            sel_d = SRC_MEM;
        else if (hit_wb_d)
            sel_d = SRC_WB;
        else
            sel_d = SRC_REGFILE;
    end

    assign sel = sel_d;

    // R3
    younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wb_we && mem_rd == src && wb_rd == src && src != ZERO_REG)
        |-> sel == SRC_MEM);

    // R5
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == ZERO_REG) |-> sel == SRC_REGFILE);

    // R4
    legal_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel != 2'b11);

    // R2
    wb_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_WB) |-> (wb_we && wb_rd == src));

endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_we,
    input  logic              ex_is_load,
    output logic              load_use
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic dep_d;
    logic load_use_d;

    always_comb begin
        dep_d      = (ex_rd == id_rs1) || (ex_rd == id_rs2);
        load_use_d = ex_is_load && ex_we && (ex_rd != ZERO_REG) && dep_d;
    end

    assign load_use = load_use_d;

    // R6
    only_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_use |-> (ex_is_load && ex_we));

    // R5
    zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == ZERO_REG) |-> !load_use);

endmodule

// File: rtl/hz_flush.sv
module hz_flush
    import hz_pkg::*;
#(
    parameter bit RESOLVE_IN_EX = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      br_resolve,
    input  logic      br_mispredict,
    input  logic      load_use,
    output pipe_ctl_t ctl
);

    localparam int SQUASH_N = RESOLVE_IN_EX ? 2 : 1;

    pipe_ctl_t ctl_d;
    logic      redirect_d;

    always_comb begin
        redirect_d     = br_resolve && br_mispredict;
        ctl_d          = '0;
        ctl_d.redirect = redirect_d;
        ctl_d.flush_f  = redirect_d;
        ctl_d.flush_d  = redirect_d && (SQUASH_N > 1);
        ctl_d.hold     = load_use && !redirect_d;
        ctl_d.bubble   = load_use && !redirect_d;
    end

    assign ctl = ctl_d;

    // R11
    squash_beats_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.flush_f |-> (!ctl.hold && !ctl.bubble));

    // R10
    quiet_without_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_resolve |-> (!ctl.flush_f && !ctl.flush_d && !ctl.redirect));

    generate
        if (SQUASH_N == 1) begin : g_early
            // R8
            one_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !ctl.flush_d);
        end else begin : g_late
            // R9
            two_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ctl.redirect |-> (ctl.flush_f && ctl.flush_d));
        end
    endgenerate

endmodule

// File: rtl/hazard_fwd_ctrl.sv
module hazard_fwd_ctrl
    import hz_pkg::*;
#(
    parameter int REG_AW        = 5,
    parameter bit RESOLVE_IN_EX = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_we,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_we,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    input  logic              br_resolve,
    input  logic              br_mispredict,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic              front_hold,
    output logic              idex_bubble,
    output logic              ifid_flush,
    output logic              idex_flush,
    output logic              fetch_redirect
);

    localparam int N_OPND = 2;
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [REG_AW-1:0] ex_src [N_OPND];
    logic [1:0]        sel    [N_OPND];
    logic              load_use;
    pipe_ctl_t         ctl;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    generate
        for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
            hz_fwd_pick #(.REG_AW(REG_AW)) u_pick (
                .clk    (clk),
                .rst_n  (rst_n),
                .src    (ex_src[g]),
                .mem_rd (mem_rd),
                .mem_we (mem_we),
                .wb_rd  (wb_rd),
                .wb_we  (wb_we),
                .sel    (sel[g])
            );
        end
    endgenerate

    hz_loaduse #(.REG_AW(REG_AW)) u_lu (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_rs1     (id_rs1),
        .id_rs2     (id_rs2),
        .ex_rd      (ex_rd),
        .ex_we      (ex_we),
        .ex_is_load (ex_is_load),
        .load_use   (load_use)
    );

    hz_flush #(.RESOLVE_IN_EX(RESOLVE_IN_EX)) u_fl (
        .clk           (clk),
        .rst_n         (rst_n),
        .br_resolve    (br_resolve),
        .br_mispredict (br_mispredict),
        .load_use      (load_use),
        .ctl           (ctl)
    );

    assign fwd_sel_a      = sel[0];
    assign fwd_sel_b      = sel[1];
    assign front_hold     = ctl.hold;
    assign idex_bubble    = ctl.bubble;
    assign ifid_flush     = ctl.flush_f;
    assign idex_flush     = ctl.flush_d;
    assign fetch_redirect = ctl.redirect;

    // R6
    hold_with_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        front_hold == idex_bubble);

    // R6
    load_dep_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_we && ex_rd != ZERO_REG && ex_rd == id_rs1 && !br_resolve)
        |-> front_hold);

    // R7
    wb_dep_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && (wb_rd == id_rs1 || wb_rd == id_rs2) && !ex_is_load)
        |-> !front_hold);

    // R1
    mem_fwd_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a == SRC_MEM && !ex_is_load) |-> !front_hold);

endmodule

// File: tb/tb_hazard_fwd_ctrl.sv
module tb_hazard_fwd_ctrl;
    localparam int CLK_P  = 10;
    localparam int REG_AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic [REG_AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic ex_we, ex_is_load, mem_we, wb_we, br_resolve, br_mispredict;

    logic [1:0] x_fa, x_fb, e_fa, e_fb;
    logic x_hold, x_bub, x_ff, x_fd, x_rd;
    logic e_hold, e_bub, e_ff, e_fd, e_rd;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    hazard_fwd_ctrl #(.REG_AW(REG_AW), .RESOLVE_IN_EX(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we),
        .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_we(mem_we),
        .wb_rd(wb_rd), .wb_we(wb_we), .br_resolve(br_resolve),
        .br_mispredict(br_mispredict), .fwd_sel_a(x_fa), .fwd_sel_b(x_fb),
        .front_hold(x_hold), .idex_bubble(x_bub), .ifid_flush(x_ff),
        .idex_flush(x_fd), .fetch_redirect(x_rd));

    hazard_fwd_ctrl #(.REG_AW(REG_AW), .RESOLVE_IN_EX(1'b0)) dut_id (
        .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we),
        .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_we(mem_we),
        .wb_rd(wb_rd), .wb_we(wb_we), .br_resolve(br_resolve),
        .br_mispredict(br_mispredict), .fwd_sel_a(e_fa), .fwd_sel_b(e_fb),
        .front_hold(e_hold), .idex_bubble(e_bub), .ifid_flush(e_ff),
        .idex_flush(e_fd), .fetch_redirect(e_rd));

    // Reference: producers listed youngest first; first enabled nonzero match wins.
    function automatic logic [1:0] ref_sel(int src);
        int       rd_q[$];
        bit       we_q[$];
        logic [1:0] code_q[$];
        rd_q.push_back(int'(mem_rd)); we_q.push_back(mem_we); code_q.push_back(2'b10);
        rd_q.push_back(int'(wb_rd));  we_q.push_back(wb_we);  code_q.push_back(2'b01);
        for (int i = 0; i < rd_q.size(); i++)
            if (we_q[i] && rd_q[i] != 0 && rd_q[i] == src) return code_q[i];
        return 2'b00;
    endfunction

    function automatic string sel_tag(int src);
        bit m = mem_we && int'(mem_rd) == src;
        bit w = wb_we && int'(wb_rd) == src;
        if (src == 0) return "R5";
        if (m && w) return "R3";
        if (m) return "R1";
        if (w) return "R2";
        return "R4";
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        int  srcs[2];
        bit  lu, squash;
        int  n_ex, n_id;
        string st;
        srcs[0] = int'(ex_rs1); srcs[1] = int'(ex_rs2);
        cmp(sel_tag(srcs[0]), "sel_a/ex", x_fa, ref_sel(srcs[0]));
        cmp(sel_tag(srcs[1]), "sel_b/ex", x_fb, ref_sel(srcs[1]));
        cmp(sel_tag(srcs[0]), "sel_a/id", e_fa, ref_sel(srcs[0]));
        cmp(sel_tag(srcs[1]), "sel_b/id", e_fb, ref_sel(srcs[1]));
        squash = br_resolve && br_mispredict;
        lu = ex_is_load && ex_we && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
        if (squash && lu) st = "R11";
        else if (lu) st = "R6";
        else if (wb_we && (wb_rd == id_rs1 || wb_rd == id_rs2)) st = "R7";
        else if (ex_rd == 0) st = "R5";
        else st = "R6";
        cmp(st, "hold/ex", x_hold, lu && !squash);
        cmp(st, "bubble/ex", x_bub, lu && !squash);
        cmp(st, "hold/id", e_hold, lu && !squash);
        cmp(st, "bubble/id", e_bub, lu && !squash);
        n_ex = squash ? 2 : 0;
        n_id = squash ? 1 : 0;
        cmp(squash ? "R9" : "R10", "flush_if/ex", x_ff, n_ex >= 1);
        cmp(squash ? "R9" : "R10", "flush_id/ex", x_fd, n_ex >= 2);
        cmp(squash ? "R9" : "R10", "redirect/ex", x_rd, squash);
        cmp(squash ? "R8" : "R10", "flush_if/id", e_ff, n_id >= 1);
        cmp(squash ? "R8" : "R10", "flush_id/id", e_fd, n_id >= 2);
        cmp(squash ? "R8" : "R10", "redirect/id", e_rd, squash);
    endtask

    task automatic drive(int i1, int i2, int x1, int x2, int xd, bit xw, bit xl,
                         int md, bit mw, int wd, bit ww, bit br, bit mp);
        @(posedge clk); #1;
        id_rs1 = REG_AW'(i1); id_rs2 = REG_AW'(i2);
        ex_rs1 = REG_AW'(x1); ex_rs2 = REG_AW'(x2);
        ex_rd = REG_AW'(xd); ex_we = xw; ex_is_load = xl;
        mem_rd = REG_AW'(md); mem_we = mw; wb_rd = REG_AW'(wd); wb_we = ww;
        br_resolve = br; br_mispredict = mp;
        @(negedge clk);
        check_all();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        id_rs1 = '0; id_rs2 = '0; ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; mem_rd = '0; wb_rd = '0;
        ex_we = 0; ex_is_load = 0; mem_we = 0; wb_we = 0; br_resolve = 0; br_mispredict = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all();                                   // reset state: R4, R10
        rst_n = 1'b1;
        drive(1,2, 3,4, 9,1,0, 3,1, 0,0, 0,0);         // R1 mem bypass on a
        drive(1,2, 3,4, 9,1,0, 0,0, 4,1, 0,0);         // R2 wb bypass on b
        drive(1,2, 5,5, 9,1,0, 5,1, 5,1, 0,0);         // R3 both match
        drive(1,2, 6,7, 9,1,0, 6,0, 7,0, 0,0);         // R4 writes disabled
        drive(0,0, 0,0, 0,1,1, 0,1, 0,1, 0,0);         // R5 register zero
        drive(8,2, 3,4, 8,1,1, 0,0, 0,0, 0,0);         // R6 load-use stall
        drive(2,8, 3,4, 8,1,0, 0,0, 0,0, 0,0);         // R6 ALU producer: no stall
        drive(10,11, 3,4, 9,1,0, 0,0, 11,1, 0,0);      // R7 wb write visible in decode
        drive(1,2, 3,4, 9,1,0, 0,0, 0,0, 1,1);         // R8 / R9 mispredict
        drive(1,2, 3,4, 9,1,0, 0,0, 0,0, 1,0);         // R10 correct prediction
        drive(1,2, 3,4, 9,1,0, 0,0, 0,0, 0,1);         // R10 flag without resolve
        drive(12,2, 3,4, 12,1,1, 0,0, 0,0, 1,1);       // R11 squash beats stall
        for (int k = 0; k < 600; k++)
            drive($urandom_range(0,3), $urandom_range(0,3), $urandom_range(0,3),
                  $urandom_range(0,3), $urandom_range(0,3), 1'($urandom_range(0,1)),
                  1'($urandom_range(0,1)), $urandom_range(0,3), 1'($urandom_range(0,1)),
                  $urandom_range(0,3), 1'($urandom_range(0,1)), 1'($urandom_range(0,1)),
                  1'($urandom_range(0,1)));
        finish_run();
    end
endmodule